// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It reads a directory entry and then a page-table entry from memory and checks both. The directory sits at a 4 KB-aligned physical base held in a loadable register. A requester hands over the linear address, a write flag and a user-mode flag through a valid/ready handshake. The walker handles one walk at a time. It reads each entry through a single word-wide memory port and enforces the present and permission bits at both levels. It writes an entry back only when the accessed or dirty flag has to change. It answers with a one-cycle response that carries either the physical address or a fault with an error code.

When a walk faults, the linear address and the error code are kept in fault registers until the next fault. While the paging enable input is low, addresses pass through untranslated and memory is never touched.

Top module: `pgwalk_top`

## Requirements
- R1: The directory entry is read at the base plus 4 times linear bits 31:22. The table entry is read at directory-entry bits 31:12 times 4096, plus 4 times linear bits 21:12.
- R2: The base register loads from `cfg_base_wdata` when `cfg_base_we` is high. Bits 11:0 of the written value are dropped and read as zero.
- R3: An entry whose bit 0 (present) is 0, at either level, ends the walk with a fault. `rsp_err[0]` is 0 and no entry is written.
- R4: A user request (`req_user`=1) faults with `rsp_err[0]`=1 if either entry has bit 2 (user) = 0. It also faults this way if it is a write and either entry has bit 1 (writable) = 0. A supervisor request never takes a permission fault.
- R5: Bit 5 (accessed) is written back into an entry only if it was 0. Each level therefore costs at most one write, and an entry that needs no change is not written.
- R6: Bit 6 (dirty) of the table entry is set only by a write request that completes without a fault.
- R7: A successful response gives `rsp_paddr` = {table entry bits 31:12, linear bits 11:0}.
- R8: On a fault, `fault_addr` takes the linear address and `fault_code` takes the error code. Both hold through later successful walks.
- R9: Error code bit 1 is the write flag of the request and bit 2 is its user flag.
- R10: With `cfg_paging_en`=0, a request answers in the cycle after acceptance with `rsp_paddr` equal to the linear address, no fault and no memory access.
- R11: `req_ready` is low from acceptance until after the response, and `rsp_valid` lasts one cycle.
- R12: A memory request keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until `mem_ack`. For a read, `mem_rdata` is taken in the `mem_ack` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base_we | input | 1 | Load the directory base register |
| cfg_base_wdata | input | 32 | New directory base (low 12 bits dropped) |
| cfg_paging_en | input | 1 | 1 = translate, 0 = pass through |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 32 | Linear address |
| req_write | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user mode |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Walk faulted |
| rsp_err | output | 3 | Error code {user, write, protection} |
| fault_addr | output | 32 | Linear address of the last fault |
| fault_code | output | 3 | Error code of the last fault |
| mem_req | output | 1 | Memory word access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
The assertions check, on every cycle, a set of protocol properties:
- the memory request stays steady until it is acknowledged;
- write-backs follow only directly after a read;
- every written entry carries the accessed flag;
- a fault is never preceded by a write;
- fault registers match the response;
- the page offset survives translation;
- the walker is busy after acceptance;
- bypass answers a cycle later without touching memory.

Only the bench scenarios can show that specific entry contents lead to the right fault kind, error bits and physical address. They also show that the dirty and accessed flags land in the right memory words with the expected number of writes, and that a faulting write leaves the dirty flag clear.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int ADDR_W  = 32;
  localparam int OFF_W   = 12;
  localparam int IDX_W   = 10;
  localparam int ENT_W   = 32;
  localparam int FRAME_W = ADDR_W - OFF_W;
  localparam int ERR_W   = 3;

  localparam int BIT_PRES = 0;
  localparam int BIT_WR   = 1;
  localparam int BIT_USR  = 2;
  localparam int BIT_ACC  = 5;
  localparam int BIT_DRT  = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DIR_RD, ST_DIR_WB, ST_TBL_RD, ST_TBL_WB, ST_DONE
  } walk_st_e;

  function automatic logic [ADDR_W-1:0] dir_slot(input logic [FRAME_W-1:0] base_frame,
                                                 input logic [IDX_W-1:0] idx);
    return {base_frame, {OFF_W{1'b0}}} + ADDR_W'({idx, 2'b00});
  endfunction

  function automatic logic [ADDR_W-1:0] tbl_slot(input logic [FRAME_W-1:0] frame,
                                                 input logic [IDX_W-1:0] idx);
    return {frame, {OFF_W{1'b0}}} + ADDR_W'({idx, 2'b00});
  endfunction

  function automatic logic [ADDR_W-1:0] page_addr(input logic [FRAME_W-1:0] frame,
                                                  input logic [OFF_W-1:0] off);
    return {frame, off};
  endfunction

  function automatic logic access_ok(input logic usr_bit, input logic wr_bit,
                                     input logic is_wr, input logic is_usr);
    return !is_usr || (usr_bit && (!is_wr || wr_bit));
  endfunction

  function automatic logic [ENT_W-1:0] entry_update(input logic [ENT_W-1:0] ent,
                                                    input logic is_wr, input logic is_tbl);
    logic [ENT_W-1:0] r;
    r = ent;
    r[BIT_ACC] = 1'b1;
    if (is_tbl && is_wr) r[BIT_DRT] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/pgwalk_entry_eval.sv
module pgwalk_entry_eval
  import pgwalk_pkg::*;
(
  input  logic [ENT_W-1:0] entry,
  input  logic             is_wr,
  input  logic             is_usr,
  input  logic             is_tbl,
  output logic             present,
  output logic             perm_ok,
  output logic [ENT_W-1:0] upd_entry,
  output logic             need_wb
);
  always_comb begin
    present   = entry[BIT_PRES];
    perm_ok   = access_ok(entry[BIT_USR], entry[BIT_WR], is_wr, is_usr);
    upd_entry = entry_update(entry, is_wr, is_tbl);
    need_wb   = (upd_entry != entry);
  end
endmodule

// File: rtl/pgwalk_walker.sv
module pgwalk_walker
  import pgwalk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] dir_base,
  input  logic              paging_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  input  logic              req_user,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_fault,
  output logic [ERR_W-1:0]  rsp_err,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [ERR_W-1:0]  fault_code,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ENT_W-1:0]  mem_wdata,
  input  logic              mem_ack,
  input  logic [ENT_W-1:0]  mem_rdata
);
  walk_st_e          st;
  logic [ADDR_W-1:0] va_q, wb_addr_q, paddr_q;
  logic              wr_q, usr_q, fault_q;
  logic [ERR_W-1:0]  err_q;
  logic [ENT_W-1:0]  ent_q;
  logic [FRAME_W-1:0] tbl_frame_q;

  // named internal events
  logic req_fire, rd_ack, ent_present, ent_perm_ok, ent_need_wb, walk_fault;
  logic [ENT_W-1:0] ent_upd;
  logic [IDX_W-1:0] dir_idx, tbl_idx;

  assign req_fire  = req_valid && req_ready;
  assign rd_ack    = mem_req && !mem_we && mem_ack;
  assign dir_idx   = va_q[ADDR_W-1 -: IDX_W];
  assign tbl_idx   = va_q[OFF_W +: IDX_W];

  pgwalk_entry_eval u_eval (
    .entry     (mem_rdata),
    .is_wr     (wr_q),
    .is_usr    (usr_q),
    .is_tbl    (st == ST_TBL_RD),
    .present   (ent_present),
    .perm_ok   (ent_perm_ok),
    .upd_entry (ent_upd),
    .need_wb   (ent_need_wb)
  );

  assign walk_fault = rd_ack && (!ent_present || !ent_perm_ok);

  always_comb begin
    req_ready = (st == ST_IDLE);
    rsp_valid = (st == ST_DONE);
    rsp_paddr = paddr_q;
    rsp_fault = fault_q;
    rsp_err   = err_q;
    mem_req   = (st == ST_DIR_RD) || (st == ST_DIR_WB) || (st == ST_TBL_RD) || (st == ST_TBL_WB);
    mem_we    = (st == ST_DIR_WB) || (st == ST_TBL_WB);
    mem_wdata = ent_q;
    case (st)
      ST_DIR_RD: mem_addr = dir_slot(dir_base[ADDR_W-1:OFF_W], dir_idx);
      ST_TBL_RD: mem_addr = tbl_slot(tbl_frame_q, tbl_idx);
      default:   mem_addr = wb_addr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      va_q        <= '0;
      wr_q        <= 1'b0;
      usr_q       <= 1'b0;
      fault_q     <= 1'b0;
      err_q       <= '0;
      paddr_q     <= '0;
      ent_q       <= '0;
      wb_addr_q   <= '0;
      tbl_frame_q <= '0;
      fault_addr  <= '0;
      fault_code  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_fire) begin
          va_q    <= req_vaddr;
          wr_q    <= req_write;
          usr_q   <= req_user;
          fault_q <= 1'b0;
          err_q   <= '0;
          paddr_q <= req_vaddr;
          st      <= paging_en ? ST_DIR_RD : ST_DONE;
        end
        ST_DIR_RD, ST_TBL_RD: if (rd_ack) begin
          wb_addr_q <= mem_addr;
          ent_q     <= ent_upd;
          if (walk_fault) begin
            fault_q    <= 1'b1;
            err_q      <= {usr_q, wr_q, ent_present};
            fault_addr <= va_q;
            fault_code <= {usr_q, wr_q, ent_present};
            paddr_q    <= '0;
            st         <= ST_DONE;
          end else if (st == ST_DIR_RD) begin
            tbl_frame_q <= mem_rdata[ENT_W-1:OFF_W];
            st          <= ent_need_wb ? ST_DIR_WB : ST_TBL_RD;
          end else begin
            paddr_q <= page_addr(mem_rdata[ENT_W-1:OFF_W], va_q[OFF_W-1:0]);
            st      <= ent_need_wb ? ST_TBL_WB : ST_DONE;
          end
        end
        ST_DIR_WB: if (mem_ack) st <= ST_TBL_RD;
        ST_TBL_WB: if (mem_ack) st <= ST_DONE;
        ST_DONE:   st <= ST_IDLE;
        default:   st <= ST_IDLE;
      endcase
    end
  end

  p_wb_accessed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[BIT_ACC]);
  p_wb_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && !$past(mem_we) |-> $past(mem_ack));
  p_no_wr_before_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> !$past(mem_we));
  p_req_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  p_fault_regs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> fault_addr == va_q && fault_code == rsp_err);
  p_offset_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]);
  p_bypass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && !paging_en |=> rsp_valid && !mem_req);
  p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_ready);
  p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_base_we,
  input  logic [ADDR_W-1:0] cfg_base_wdata,
  input  logic              cfg_paging_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  input  logic              req_user,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_fault,
  output logic [ERR_W-1:0]  rsp_err,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [ERR_W-1:0]  fault_code,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ENT_W-1:0]  mem_wdata,
  input  logic              mem_ack,
  input  logic [ENT_W-1:0]  mem_rdata
);
  localparam logic [ADDR_W-1:0] FRAME_MASK = ~ADDR_W'((64'd1 << OFF_W) - 1);

  logic [ADDR_W-1:0] base_q;

  // R2: base register keeps only the 4 KB frame bits
  always_ff @(posedge clk) begin
    if (!rst_n)           base_q <= '0;
    else if (cfg_base_we) base_q <= cfg_base_wdata & FRAME_MASK;
  end

  pgwalk_walker u_walker (
    .clk        (clk),
    .rst_n      (rst_n),
    .dir_base   (base_q),
    .paging_en  (cfg_paging_en),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_vaddr  (req_vaddr),
    .req_write  (req_write),
    .req_user   (req_user),
    .rsp_valid  (rsp_valid),
    .rsp_paddr  (rsp_paddr),
    .rsp_fault  (rsp_fault),
    .rsp_err    (rsp_err),
    .fault_addr (fault_addr),
    .fault_code (fault_code),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata)
  );
endmodule

// File: tb/pgwalk_top_tb_top.sv
module pgwalk_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_base_we = 1'b0;
  logic [31:0] cfg_base_wdata = '0;
  logic        cfg_paging_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rsp_paddr, fault_addr;
  logic [2:0]  rsp_err, fault_code;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int errors = 0;
  int checks = 0;
  int wr_count = 0;
  int rd_count = 0;
  int cycles = 0;
  logic [31:0] mem [0:4095];

  always #4 clk = ~clk;

  pgwalk_top dut_i (.*);

  // simple word memory, one-cycle acknowledge
  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        mem_rdata <= mem[mem_addr[13:2]];
        if (mem_we) begin
          mem[mem_addr[13:2]] <= mem_wdata;
          wr_count <= wr_count + 1;
        end else rd_count <= rd_count + 1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
      end
    end
  end

  task automatic do_req(input logic [31:0] va, input logic wr, input logic usr,
                        output logic flt, output logic [2:0] err, output logic [31:0] pa,
                        output int lat);
    lat = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 busy after accept", {31'd0, req_ready}, 32'd0);
    while (!rsp_valid && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    flt = rsp_fault; err = rsp_err; pa = rsp_paddr;
    @(negedge clk);
    check("R11 one-cycle response", {31'd0, rsp_valid}, 32'd0);
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic        usr;
    logic        flt;
    logic [2:0]  err;
    logic [31:0] pa;
    logic [3:0]  nwr;
  } vec_t;

  // err = {user, write, protection}
  localparam vec_t VECS [0:10] = '{
    '{32'h3E837B0A, 1'b0, 1'b1, 1'b0, 3'b000, 32'h0001BB0A, 4'd2},  // R7 R5
    '{32'h3E810123, 1'b0, 1'b1, 1'b0, 3'b000, 32'h00055123, 4'd1},  // R5
    '{32'h3E810123, 1'b1, 1'b1, 1'b1, 3'b111, 32'h00000000, 4'd0},  // R4 R6 R9
    '{32'h3E810123, 1'b1, 1'b0, 1'b0, 3'b000, 32'h00055123, 4'd1},  // R4 R6
    '{32'h3E811456, 1'b0, 1'b1, 1'b1, 3'b100, 32'h00000000, 4'd0},  // R3 table
    '{32'h00800ABC, 1'b1, 1'b0, 1'b1, 3'b010, 32'h00000000, 4'd0},  // R3 directory
    '{32'h00404FFF, 1'b0, 1'b1, 1'b1, 3'b101, 32'h00000000, 4'd0},  // R4 directory
    '{32'h00404FFF, 1'b0, 1'b0, 1'b0, 3'b000, 32'h00077FFF, 4'd1},  // R4 supervisor
    '{32'h00404FFF, 1'b1, 1'b0, 1'b0, 3'b000, 32'h00077FFF, 4'd1},  // R6
    '{32'h00404FFF, 1'b1, 1'b0, 1'b0, 3'b000, 32'h00077FFF, 4'd0},  // R5 no change
    '{32'h3E837B0A, 1'b1, 1'b1, 1'b0, 3'b000, 32'h0001BB0A, 4'd1}   // R6 R7
  };

  initial begin
    logic flt;
    logic [2:0] err;
    logic [31:0] pa;
    logic [31:0] exp_faddr;
    logic [2:0] exp_fcode;
    int lat;
    int w0;
    int r0;
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    mem[12'h4FA] = 32'h00002007;  // dir 0x0FA: P RW U, A clear
    mem[12'h401] = 32'h00003021;  // dir 0x001: P, supervisor, read-only, A set
    mem[12'h837] = 32'h0001B007;  // table 0x037
    mem[12'h810] = 32'h00055005;  // table 0x010: P U read-only
    mem[12'hC04] = 32'h00077003;  // table 0x004 under dir 1: P RW supervisor

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("reset req_ready", {31'd0, req_ready}, 32'd1);
    check("reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("reset mem_req",   {31'd0, mem_req}, 32'd0);
    check("reset fault_addr", fault_addr, 32'd0);

    // R2/R1: unaligned base loaded, directory slot address
    cfg_base_we = 1'b1; cfg_base_wdata = 32'h12345ABC;
    @(negedge clk);
    cfg_base_we = 1'b0; cfg_paging_en = 1'b1;
    req_valid = 1'b1; req_vaddr = 32'h00C00000; req_write = 1'b0; req_user = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 R2 directory slot address", mem_addr, 32'h1234500C);
    while (!rsp_valid) @(negedge clk);
    check("R3 not-present fault", {31'd0, rsp_fault}, 32'd1);
    check("R3 R9 error code", {29'd0, rsp_err}, 32'd0);
    check("R8 fault address", fault_addr, 32'h00C00000);
    exp_faddr = 32'h00C00000; exp_fcode = 3'b000;
    @(negedge clk);

    cfg_base_we = 1'b1; cfg_base_wdata = 32'h00001000;
    @(negedge clk);
    cfg_base_we = 1'b0;

    for (int i = 0; i < 11; i++) begin
      w0 = wr_count;
      do_req(VECS[i].va, VECS[i].wr, VECS[i].usr, flt, err, pa, lat);
      check($sformatf("R3 R4 fault flag vec%0d", i), {31'd0, flt}, {31'd0, VECS[i].flt});
      check($sformatf("R9 error code vec%0d", i), {29'd0, err}, {29'd0, VECS[i].err});
      check($sformatf("R7 physical address vec%0d", i), pa, VECS[i].pa);
      check($sformatf("R5 R6 write-backs vec%0d", i), wr_count - w0, {28'd0, VECS[i].nwr});
      if (VECS[i].flt) begin exp_faddr = VECS[i].va; exp_fcode = VECS[i].err; end
      check($sformatf("R8 fault_addr vec%0d", i), fault_addr, exp_faddr);
      check($sformatf("R8 fault_code vec%0d", i), {29'd0, fault_code}, {29'd0, exp_fcode});
    end

    check("R5 directory accessed set", mem[12'h4FA], 32'h00002027);
    check("R5 directory untouched when accessed", mem[12'h401], 32'h00003021);
    check("R6 dirty after write", mem[12'h837], 32'h0001B067);
    check("R6 dirty after supervisor write", mem[12'h810], 32'h00055065);
    check("R6 R5 table entry flags", mem[12'hC04], 32'h00077063);

    // R10: bypass
    cfg_paging_en = 1'b0;
    w0 = wr_count; r0 = rd_count;
    do_req(32'hDEADBEEF, 1'b1, 1'b1, flt, err, pa, lat);
    check("R10 bypass latency", lat, 0);
    check("R10 bypass address", pa, 32'hDEADBEEF);
    check("R10 bypass no fault", {31'd0, flt}, 32'd0);
    check("R10 no memory access", (wr_count - w0) + (rd_count - r0), 0);
    check("R8 fault_addr held", fault_addr, exp_faddr);

    finish_run();
  end
endmodule